// File: doc/BRIEF.md
# Steered Replicated-Register Access Sequencer

This block carries out one access to a replicated register on a register bus that it shares with an outside agent. A steered access first claims a hardware semaphore. It then writes a steering selector with a group and an instance, does the read or write, puts the selector back into broadcast mode when the access was a write, and finally frees the semaphore. A broadcast write claims and frees the semaphore but never touches the selector, because broadcast mode is already in force between accesses. A direct access skips both the semaphore and the selector.

Requests come in through a valid/ready pair. One request is in flight at a time, and its end is marked by a one-cycle done pulse. The block is the bus master. It holds each bus request steady until the bus acknowledges it. Polling for the semaphore is bounded by a cycle budget. When the budget runs out, the sequence goes on anyway and a sticky timeout flag is raised.

Top module: `steer_seq`

## Requirements
- R1: In steered and broadcast modes, the first bus access is a read of SEM_ADDR. This read is repeated until a reply has bit 0 equal to 1, and only then does the sequence continue. A bus request stays asserted, with address, direction and data unchanged, until it is acknowledged.
- R2: Suppose a failing semaphore reply arrives at the end of a cycle that brings the number of polling cycles to TIMEOUT_CYC or more. The cycle in which the first poll is issued counts as one. Polling then stops, the sequence continues as though the semaphore had been granted, and rsp_timeout goes to 1. The flag stays at 1 until the next request is accepted.
- R3: Every sequence that polled the semaphore ends with a write of the value 1 to SEM_ADDR.
- R4: A steered read (mode 0, req_write 0) writes SEL_ADDR with the instance in bits [IW-1:0], the group in bits [IW+GW-1:IW] and bit MC_POS set. It then reads the target address. The value read appears on rsp_rdata once done has pulsed.
- R5: A steered write (mode 0, req_write 1) writes SEL_ADDR with the same group and instance fields and bit MC_POS clear. It then writes req_wdata to the target, and after that writes SEL_ADDR with only bit MC_POS set. The selector is never read.
- R6: A broadcast write (mode 1) does three things in order: the semaphore poll, a write of req_wdata to the target, and the release. It writes even when req_write is 0, and it makes no selector access.
- R7: A direct access (mode 2, and also the reserved mode 3) makes exactly one bus access, a read or write of the target address, with no semaphore or selector traffic. No bus request is made while the block is idle.
- R8: req_ready is low from the cycle after acceptance until done has pulsed. rsp_done is high for exactly one cycle, and req_ready is high again in the following cycle.
- R9: After reset, req_ready is 1 and rsp_done, rsp_timeout and bus_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_mode | input | 2 | 0 steered, 1 broadcast write, 2/3 direct |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Target register address |
| req_group | input | GW | Steering group |
| req_inst | input | IW | Steering instance |
| req_wdata | input | DW | Write data |
| rsp_rdata | output | DW | Data from the latest target read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_timeout | output | 1 | Sticky semaphore timeout flag |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Bus write enable |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_ack | input | 1 | Bus access complete |
| bus_rdata | input | DW | Bus read data, valid with bus_ack |

## Verification
A wrong state step shows on the bus within a single access. The bench records the whole bus transaction log for each request and compares it with the sequence it expects. A skipped selector restore, a broadcast write that goes through the selector, or a release that is missing is therefore caught on the first request of that kind. A miscounted poll timer changes the number of semaphore reads within one timeout window and changes the value of rsp_timeout at done. A latch that captures in the wrong state corrupts rsp_rdata on the first steered or direct read.

// File: rtl/steer_pkg.sv
package steer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCK,
        ST_SEL,
        ST_ACC,
        ST_UNSEL,
        ST_FREE,
        ST_DONE
    } st_e;

    typedef enum logic [1:0] {
        MD_STEER  = 2'd0,
        MD_BCAST  = 2'd1,
        MD_DIRECT = 2'd2,
        MD_RSVD   = 2'd3
    } mode_e;

    // Successor of a bus state once its access has been acknowledged.
    function automatic st_e step_on_ack(st_e s, mode_e m, logic wr, logic sem_ok);
        st_e n;
        n = s;
        case (s)
            ST_LOCK:  n = sem_ok ? ((m == MD_STEER) ? ST_SEL : ST_ACC) : ST_LOCK;
            ST_SEL:   n = ST_ACC;
            ST_ACC:   n = (m == MD_DIRECT) ? ST_DONE :
                          ((m == MD_STEER) && wr) ? ST_UNSEL : ST_FREE;
            ST_UNSEL: n = ST_FREE;
            ST_FREE:  n = ST_DONE;
            default:  n = s;
        endcase
        return n;
    endfunction

    function automatic mode_e norm_mode(logic [1:0] raw);
        return (raw == MD_RSVD) ? MD_DIRECT : mode_e'(raw);
    endfunction

endpackage

// File: rtl/steer_tmo.sv
module steer_tmo #(
    parameter int LIMIT = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run && cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    // cnt holds the cycles already spent; the current cycle adds one.
    assign expired = (cnt >= LAST);

endmodule

// File: rtl/steer_busmux.sv
module steer_busmux
    import steer_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 32,
    parameter int GW = 4,
    parameter int IW = 4,
    parameter int MC_POS = 31,
    parameter logic [AW-1:0] SEL_ADDR = 'h00FDC,
    parameter logic [AW-1:0] SEM_ADDR = 'h00FD0
) (
    input  st_e           st,
    input  logic [AW-1:0] tgt_addr,
    input  logic          tgt_wr,
    input  logic [GW-1:0] grp,
    input  logic [IW-1:0] inst,
    input  logic [DW-1:0] tgt_wdata,
    output logic          req,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata
);
    logic [DW-1:0] sel_word;
    logic [DW-1:0] mc_only;

    always_comb begin
        sel_word = '0;
        sel_word[IW-1:0]     = inst;
        sel_word[IW+GW-1:IW] = grp;
        sel_word[MC_POS]     = ~tgt_wr;
        mc_only = '0;
        mc_only[MC_POS] = 1'b1;
    end

    always_comb begin
        req   = 1'b1;
        we    = 1'b0;
        addr  = tgt_addr;
        wdata = '0;
        case (st)
            ST_LOCK:  begin addr = SEM_ADDR; end
            ST_SEL:   begin we = 1'b1; addr = SEL_ADDR; wdata = sel_word; end
            ST_ACC:   begin we = tgt_wr; wdata = tgt_wdata; end
            ST_UNSEL: begin we = 1'b1; addr = SEL_ADDR; wdata = mc_only; end
            ST_FREE:  begin we = 1'b1; addr = SEM_ADDR; wdata = DW'(1); end
            default:  begin req = 1'b0; end
        endcase
    end

endmodule

// File: rtl/steer_seq.sv
module steer_seq
    import steer_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 32,
    parameter int GW = 4,
    parameter int IW = 4,
    parameter int MC_POS = 31,
    parameter int TIMEOUT_CYC = 500,
    parameter logic [AW-1:0] SEL_ADDR = 'h00FDC,
    parameter logic [AW-1:0] SEM_ADDR = 'h00FD0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_mode,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [GW-1:0] req_group,
    input  logic [IW-1:0] req_inst,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_done,
    output logic          rsp_timeout,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata
);
    st_e           st;
    mode_e         r_mode;
    mode_e         in_mode;
    logic          r_wr;
    logic [AW-1:0] r_addr;
    logic [GW-1:0] r_grp;
    logic [IW-1:0] r_inst;
    logic [DW-1:0] r_wdata;
    logic [DW-1:0] rdata_q;
    logic          tmo_q;
    logic          accept;
    logic          expired;
    logic          sem_ok;

    assign in_mode   = norm_mode(req_mode);
    assign req_ready = (st == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign sem_ok    = bus_rdata[0] || expired;

    steer_tmo #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .clr     (accept),
        .run     (st == ST_LOCK),
        .expired (expired)
    );

    steer_busmux #(
        .AW(AW), .DW(DW), .GW(GW), .IW(IW), .MC_POS(MC_POS),
        .SEL_ADDR(SEL_ADDR), .SEM_ADDR(SEM_ADDR)
    ) u_mux (
        .st        (st),
        .tgt_addr  (r_addr),
        .tgt_wr    (r_wr),
        .grp       (r_grp),
        .inst      (r_inst),
        .tgt_wdata (r_wdata),
        .req       (bus_req),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            r_mode  <= MD_DIRECT;
            r_wr    <= 1'b0;
            r_addr  <= '0;
            r_grp   <= '0;
            r_inst  <= '0;
            r_wdata <= '0;
            rdata_q <= '0;
            tmo_q   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        r_mode  <= in_mode;
                        r_wr    <= req_write || (in_mode == MD_BCAST);
                        r_addr  <= req_addr;
                        r_grp   <= req_group;
                        r_inst  <= req_inst;
                        r_wdata <= req_wdata;
                        tmo_q   <= 1'b0;
                        st      <= (in_mode == MD_DIRECT) ? ST_ACC : ST_LOCK;
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: begin
                    if (bus_ack) begin
                        if (st == ST_LOCK && !bus_rdata[0] && expired) begin
                            tmo_q <= 1'b1;
                        end
                        if (st == ST_ACC && !r_wr) begin
                            rdata_q <= bus_rdata;
                        end
                        st <= step_on_ack(st, r_mode, r_wr, sem_ok);
                    end
                end
            endcase
        end
    end

    assign rsp_rdata   = rdata_q;
    assign rsp_done    = (st == ST_DONE);
    assign rsp_timeout = tmo_q;

endmodule

// File: rtl/steer_seq_chk.sv
module steer_seq_chk #(
    parameter int AW = 24,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_done,
    input logic          rsp_timeout,
    input logic          bus_req,
    input logic          bus_we,
    input logic          bus_ack,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata
);
    p_reset_state_r9: assert property (@(posedge clk)
        rst |=> (req_ready && !rsp_done && !bus_req && !rsp_timeout));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> (!rsp_done && req_ready));

    p_busy_at_done_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> !req_ready);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !bus_req);

    p_hold_until_ack_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    p_timeout_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_timeout && !(req_valid && req_ready)) |=> rsp_timeout);

endmodule

bind steer_seq steer_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .rsp_timeout (rsp_timeout),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_ack     (bus_ack),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata)
);

// File: tb/sim_steer_seq.sv
`timescale 1ns/1ps
module sim_steer_seq;
    localparam int AW = 24;
    localparam int DW = 32;
    localparam int GW = 2;
    localparam int IW = 2;
    localparam int MCP = 31;
    localparam int TMO = 20;
    localparam logic [AW-1:0] SELA = 24'h000FDC;
    localparam logic [AW-1:0] SEMA = 24'h000FD0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_mode = 2'd0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [GW-1:0] req_group = '0;
    logic [IW-1:0] req_inst = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_done;
    logic          rsp_timeout;
    logic          bus_req;
    logic          bus_we;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    int sem_fail_left = 0;
    bit sem_never = 0;

    logic          lg_we   [0:31];
    logic [AW-1:0] lg_addr [0:31];
    logic [DW-1:0] lg_data [0:31];
    int            lg_n = 0;
    logic          e_we    [0:31];
    logic [AW-1:0] e_addr  [0:31];
    logic [DW-1:0] e_data  [0:31];
    int            e_n = 0;

    always #10 clk = ~clk;

    steer_seq #(
        .AW(AW), .DW(DW), .GW(GW), .IW(IW), .MC_POS(MCP),
        .TIMEOUT_CYC(TMO), .SEL_ADDR(SELA), .SEM_ADDR(SEMA)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_write(req_write), .req_addr(req_addr),
        .req_group(req_group), .req_inst(req_inst), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_timeout(rsp_timeout),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    function automatic logic [DW-1:0] rd_fn(input logic [AW-1:0] a);
        return {8'hC3, a};
    endfunction

    function automatic logic [DW-1:0] sel_val(input int g, input int i, input bit mc);
        return (DW'(mc) << MCP) | DW'(g * (1 << IW)) | DW'(i);
    endfunction

    // Bus responder: acknowledges every other cycle and logs each access.
    always @(negedge clk) begin
        if (rst) begin
            bus_ack = 1'b0;
        end else if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            bus_ack = 1'b1;
            if (bus_we) begin
                bus_rdata = '0;
            end else if (bus_addr == SEMA) begin
                if (sem_never || sem_fail_left > 0) begin
                    bus_rdata = '0;
                    if (sem_fail_left > 0) sem_fail_left--;
                end else begin
                    bus_rdata = DW'(1);
                end
            end else begin
                bus_rdata = rd_fn(bus_addr);
            end
            if (lg_n < 32) begin
                lg_we[lg_n]   = bus_we;
                lg_addr[lg_n] = bus_addr;
                lg_data[lg_n] = bus_we ? bus_wdata : bus_rdata;
                lg_n++;
            end
        end
    end

    task automatic chk(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic push(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        e_we[e_n] = we; e_addr[e_n] = a; e_data[e_n] = d; e_n++;
    endtask

    task automatic cmp_log(input string rq);
        chk({rq, " access count"}, DW'(lg_n), DW'(e_n));
        for (int j = 0; j < e_n && j < lg_n; j++) begin
            chk({rq, " we"},   DW'(lg_we[j]),   DW'(e_we[j]));
            chk({rq, " addr"}, DW'(lg_addr[j]), DW'(e_addr[j]));
            chk({rq, " data"}, lg_data[j],      e_data[j]);
        end
    endtask

    task automatic issue(input logic [1:0] md, input logic wr, input logic [AW-1:0] a,
                         input int g, input int i, input logic [DW-1:0] wd);
        int cyc;
        int busy_bad;
        @(negedge clk);
        lg_n = 0;
        e_n = 0;
        req_mode = md; req_write = wr; req_addr = a;
        req_group = GW'(g); req_inst = IW'(i); req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        busy_bad = 0;
        while (!rsp_done && cyc < 200) begin
            if (req_ready) busy_bad++;
            @(negedge clk);
            cyc++;
        end
        chk("R8 done reached", DW'(rsp_done), DW'(1));
        chk("R8 ready low while busy", DW'(busy_bad + (req_ready ? 1 : 0)), DW'(0));
    endtask

    task automatic after_done;
        @(negedge clk);
        chk("R8 done one cycle", DW'(rsp_done), DW'(0));
        chk("R8 ready back", DW'(req_ready), DW'(1));
    endtask

    initial begin
        #(20.0 * 150000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 ready", DW'(req_ready), DW'(1));
        chk("R9 done", DW'(rsp_done), DW'(0));
        chk("R9 timeout", DW'(rsp_timeout), DW'(0));
        chk("R9 bus_req", DW'(bus_req), DW'(0));
        rst = 1'b0;
        @(negedge clk);

        // R4 / R5: steered reads and writes over every group and instance
        for (int g = 0; g < (1 << GW); g++) begin
            for (int i = 0; i < (1 << IW); i++) begin
                logic [AW-1:0] a;
                logic [DW-1:0] wd;
                a = 24'h00B100 + AW'(g * 16 + i);
                wd = 32'h5A000000 + DW'(g * 256 + i * 7);
                issue(2'd0, 1'b0, a, g, i, '0);
                push(1'b0, SEMA, DW'(1));
                push(1'b1, SELA, sel_val(g, i, 1'b1));
                push(1'b0, a, rd_fn(a));
                push(1'b1, SEMA, DW'(1));
                cmp_log("R4 steered read");
                chk("R4 rdata", rsp_rdata, rd_fn(a));
                chk("R2 no timeout", DW'(rsp_timeout), DW'(0));
                after_done();

                issue(2'd0, 1'b1, a, g, i, wd);
                push(1'b0, SEMA, DW'(1));
                push(1'b1, SELA, sel_val(g, i, 1'b0));
                push(1'b1, a, wd);
                push(1'b1, SELA, sel_val(0, 0, 1'b1));
                push(1'b1, SEMA, DW'(1));
                cmp_log("R5 steered write");
                chk("R5 rdata kept", rsp_rdata, rd_fn(a));
                after_done();
            end
        end

        // R1: semaphore granted after several failed polls
        for (int nf = 1; nf <= 4; nf++) begin
            sem_fail_left = nf;
            issue(2'd0, 1'b0, 24'h00DD40, 1, 2, '0);
            for (int k = 0; k < nf; k++) push(1'b0, SEMA, '0);
            push(1'b0, SEMA, DW'(1));
            push(1'b1, SELA, sel_val(1, 2, 1'b1));
            push(1'b0, 24'h00DD40, rd_fn(24'h00DD40));
            push(1'b1, SEMA, DW'(1));
            cmp_log("R1 poll until one");
            chk("R2 no timeout with grant", DW'(rsp_timeout), DW'(0));
            after_done();
        end

        // R6: broadcast writes, including req_write low
        for (int k = 0; k < 4; k++) begin
            logic [AW-1:0] a;
            a = 24'h00F000 + AW'(k * 4);
            issue(2'd1, k[0], a, 3, 3, 32'hB0000000 + DW'(k));
            push(1'b0, SEMA, DW'(1));
            push(1'b1, a, 32'hB0000000 + DW'(k));
            push(1'b1, SEMA, DW'(1));
            cmp_log("R6 broadcast write");
            after_done();
        end

        // R7: direct accesses, modes 2 and 3
        for (int md = 2; md < 4; md++) begin
            issue(2'(md), 1'b0, 24'h001234, 2, 1, '0);
            push(1'b0, 24'h001234, rd_fn(24'h001234));
            cmp_log("R7 direct read");
            chk("R7 direct rdata", rsp_rdata, rd_fn(24'h001234));
            after_done();
            issue(2'(md), 1'b1, 24'h004321, 2, 1, 32'hCAFE0000 + DW'(md));
            push(1'b1, 24'h004321, 32'hCAFE0000 + DW'(md));
            cmp_log("R7 direct write");
            chk("R7 rdata unchanged", rsp_rdata, rd_fn(24'h001234));
            after_done();
        end

        // R2 / R3: semaphore never granted; give up after the budget
        sem_never = 1;
        issue(2'd0, 1'b1, 24'h009520, 2, 3, 32'h0000BEEF);
        for (int k = 0; k < (TMO + 2) / 2; k++) push(1'b0, SEMA, '0);
        push(1'b1, SELA, sel_val(2, 3, 1'b0));
        push(1'b1, 24'h009520, 32'h0000BEEF);
        push(1'b1, SELA, sel_val(0, 0, 1'b1));
        push(1'b1, SEMA, DW'(1));
        cmp_log("R2 timeout sequence with R3 release");
        chk("R2 timeout flag at done", DW'(rsp_timeout), DW'(1));
        after_done();
        repeat (3) @(negedge clk);
        chk("R2 timeout sticky", DW'(rsp_timeout), DW'(1));
        sem_never = 0;

        // R2: next accepted request clears the flag
        @(negedge clk);
        req_mode = 2'd2; req_write = 1'b0; req_addr = 24'h000100; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 flag cleared on accept", DW'(rsp_timeout), DW'(0));
        repeat (6) @(negedge clk);
        chk("R7 idle after direct", DW'(req_ready), DW'(1));

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule